// File: doc/BRIEF.md
# Single-Wire Smart-Card Character Transmitter

This block sends bytes over a half-duplex serial link whose transmit and receive pins share one wire. A host writes a byte into a one-entry holding buffer. While transmission is enabled, the byte moves into a frame shift register and goes out as an eleven-bit character. The bit rate comes from a programmable divisor applied to an enable pulse from the chosen count source.

The line output is open-drain. The block pulls the wire low for a 0 bit and lets it float high for a 1 bit, so the far-end receiver can pull the same wire low. In the middle of the stop bit the block reads the shared wire. A low level at that point means the receiver is reporting a parity error, and the block records it in a sticky flag. A transmit-complete request is raised at the end of every stop bit and held until it is acknowledged.

The `line_in` input is assumed to be already synchronised to `clk`.

Top module: `sc_uart_tx`

## Requirements
- R1: Each character on the line is, in order: a start bit at 0, the eight data bits least significant bit first, one even-parity bit (the parity bit is the XOR of the data bits, so the count of ones over data and parity is even), and a stop bit at 1. No bit is inverted.
- R2: Each bit lasts 16 × (div_n + 1) clock cycles in which `tick_en` is 1. Cycles with `tick_en` at 0 do not advance the bit timing. With `tick_en` held at 1 and div_n = 0, `shift_empty` stays 0 for exactly 176 cycles per character.
- R3: `line_drive_low` is 1 only while a 0 bit is being sent. It is 0 during 1 bits and whenever no character is in progress.
- R4: A buffered byte moves into the shift register only while `tx_en` is 1. If `tx_en` falls during a character, that character still completes, and the next buffered byte waits in the buffer.
- R5: `shift_empty` is 1 at idle. It goes to 0 in the cycle after the byte moves into the shift register, and returns to 1 in the cycle after the last count of the stop bit.
- R6: `buf_empty` goes to 0 in the cycle after `wr_en` is sampled at 1. It returns to 1 in the cycle after the byte moves into the shift register.
- R7: `irq` is set at the end of the stop bit. It stays set until `irq_ack` is sampled at 1. If a set and an acknowledge happen in the same cycle, the set wins.
- R8: `line_in` is sampled at the enabled tick that completes 8 × (div_n + 1) counts of the stop bit. A low level there sets `err_flag`, which holds until `err_clr` is sampled at 1 (a set in the same cycle wins). A low level only earlier in the stop bit sets nothing.
- R9: While `rst` is 1, and in the cycle after it, `line_drive_low` = 0, `buf_empty` = 1, `shift_empty` = 1, `irq` = 0 and `err_flag` = 0.
- R10: A byte that is buffered while a character is in progress loads in the cycle right after that character ends. `shift_empty` is therefore 1 for exactly one cycle between the two characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable from the selected count source |
| div_n | input | DIV_W | Divisor value n; a bit lasts 16 × (n + 1) ticks |
| tx_en | input | 1 | Transmit enable |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| irq_ack | input | 1 | Clears the transmit-complete request |
| err_clr | input | 1 | Clears the error-signal flag |
| line_in | input | 1 | Level read back from the shared wire |
| line_drive_low | output | 1 | 1 = pull the wire low, 0 = release it |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | No character is being shifted |
| irq | output | 1 | Transmit-complete request |
| err_flag | output | 1 | Sticky flag for an error signal seen in the stop bit |

## Verification
The bench builds the block with DIV_W = 4. It runs in two regimes. In the first, div_n = 0 and `tick_en` is held at 1, which gives short 16-cycle bits, so the exact character length, the one-cycle gap between characters and the placement of the stop-bit sample can all be counted directly. In the second, div_n = 2 and `tick_en` is pulsed every other cycle, which checks that the divisor value and the stalled cycles both stretch the bit correctly. The bench pulls the shared wire low for the whole stop bit in one case, and only for its first few counts in another, so both sides of the mid-bit sample are covered.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int OVS_LOG2   = 4;

  typedef enum logic {ST_IDLE, ST_SEND} tx_state_e;

  function automatic logic even_parity(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_tx_bitclk.sv
module sc_tx_bitclk import sc_tx_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_n,
  output logic             half_hit,
  output logic             bit_end
);
  localparam int CW = DIV_W + OVS_LOG2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] half_cnt;

  // 16*(n+1)-1 and 8*(n+1)-1 built from shifts
  assign last_cnt = {div_n, {OVS_LOG2{1'b1}}};
  assign half_cnt = {1'b0, div_n, {(OVS_LOG2-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == last_cnt) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_end  = run && tick && (cnt_q == last_cnt);
  assign half_hit = run && tick && (cnt_q == half_cnt);
endmodule

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter import sc_tx_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_end,
  output logic              busy,
  output logic              buf_full,
  output logic              last_bit,
  output logic              frame_done,
  output logic              drive_low
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  tx_state_e            st_q;
  logic [DATA_W-1:0]    hold_q;
  logic                 full_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 drv_q;
  logic                 load;

  assign load       = (st_q == ST_IDLE) && full_q && tx_en;
  assign last_bit   = (st_q == ST_SEND) && (idx_q == LAST_IDX);
  assign frame_done = last_bit && bit_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      frame_q <= '1;
      idx_q   <= '0;
      drv_q   <= 1'b0;
    end else if (load) begin
      st_q    <= ST_SEND;
      frame_q <= {1'b1, even_parity(hold_q), hold_q, 1'b0};
      idx_q   <= '0;
      drv_q   <= 1'b1;
    end else if (st_q == ST_SEND && bit_end) begin
      if (idx_q == LAST_IDX) begin
        st_q  <= ST_IDLE;
        drv_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        drv_q <= ~frame_q[1];
      end
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (wr_en) begin
        full_q <= 1'b1;
        hold_q <= wr_data;
      end else if (load) begin
        full_q <= 1'b0;
      end
    end
  end

  assign busy      = (st_q == ST_SEND);
  assign buf_full  = full_q;
  assign drive_low = drv_q;
endmodule

// File: rtl/sc_tx_sticky.sv
module sc_tx_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)         flag_q <= 1'b0;
      else if (set[i]) flag_q <= 1'b1;
      else if (clr[i]) flag_q <= 1'b0;
    end
    assign q[i] = flag_q;
  end
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx import sc_tx_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [DIV_W-1:0] div_n,
  input  logic             tx_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             irq_ack,
  input  logic             err_clr,
  input  logic             line_in,
  output logic             line_drive_low,
  output logic             buf_empty,
  output logic             shift_empty,
  output logic             irq,
  output logic             err_flag
);
  localparam int FLAG_IRQ = 0;
  localparam int FLAG_ERR = 1;

  logic       busy;
  logic       buf_full;
  logic       last_bit;
  logic       frame_done;
  logic       half_hit;
  logic       bit_end;
  logic [1:0] flag_set;
  logic [1:0] flag_clr;
  logic [1:0] flag_q;

  sc_tx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .tick     (tick_en),
    .div_n    (div_n),
    .half_hit (half_hit),
    .bit_end  (bit_end)
  );

  sc_tx_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .bit_end    (bit_end),
    .busy       (busy),
    .buf_full   (buf_full),
    .last_bit   (last_bit),
    .frame_done (frame_done),
    .drive_low  (line_drive_low)
  );

  // mid-stop-bit read of the shared wire
  assign flag_set[FLAG_IRQ] = frame_done;
  assign flag_set[FLAG_ERR] = last_bit && half_hit && !line_in;
  assign flag_clr[FLAG_IRQ] = irq_ack;
  assign flag_clr[FLAG_ERR] = err_clr;

  sc_tx_sticky #(.N(2)) u_flags (
    .clk (clk),
    .rst (rst),
    .set (flag_set),
    .clr (flag_clr),
    .q   (flag_q)
  );

  assign irq         = flag_q[FLAG_IRQ];
  assign err_flag    = flag_q[FLAG_ERR];
  assign buf_empty   = ~buf_full;
  assign shift_empty = ~busy;
endmodule

// File: rtl/sc_uart_tx_chk.sv
module sc_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic wr_en,
  input logic irq_ack,
  input logic err_clr,
  input logic line_drive_low,
  input logic buf_empty,
  input logic shift_empty,
  input logic irq,
  input logic err_flag
);
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> !line_drive_low);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  assert_buf_fill_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_empty) |-> $past(wr_en));

  assert_load_gate_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> $past(tx_en && !buf_empty));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (buf_empty && shift_empty && !irq && !err_flag && !line_drive_low));
endmodule

bind sc_uart_tx sc_uart_tx_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .tx_en          (tx_en),
  .wr_en          (wr_en),
  .irq_ack        (irq_ack),
  .err_clr        (err_clr),
  .line_drive_low (line_drive_low),
  .buf_empty      (buf_empty),
  .shift_empty    (shift_empty),
  .irq            (irq),
  .err_flag       (err_flag)
);

// File: tb/sc_uart_tx_test.sv
`timescale 1ns/1ps
module sc_uart_tx_test;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             tick_en = 1'b1;
  logic [DIV_W-1:0] div_n = '0;
  logic             tx_en = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             irq_ack = 1'b0;
  logic             err_clr = 1'b0;
  logic             nack = 1'b0;
  logic             tick_alt = 1'b0;
  logic             line_in;
  logic             line_drive_low, buf_empty, shift_empty, irq, err_flag;

  int errors = 0;
  int checks = 0;

  assign line_in = !line_drive_low && !nack;

  sc_uart_tx #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .div_n(div_n), .tx_en(tx_en),
    .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack), .err_clr(err_clr),
    .line_in(line_in), .line_drive_low(line_drive_low), .buf_empty(buf_empty),
    .shift_empty(shift_empty), .irq(irq), .err_flag(err_flag)
  );

  // behavioural reference: queue of pending line levels
  bit       fq[$];
  int       m_cnt = 0;
  bit       m_busy = 0, m_full = 0, m_irq = 0, m_err = 0;
  bit [7:0] m_data = 0;

  function automatic bit m_drive();
    return m_busy && fq.size() > 0 && fq[0] == 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      fq.delete(); m_cnt = 0; m_busy = 0; m_full = 0; m_irq = 0; m_err = 0; m_data = 0;
    end else begin
      bit line, set_irq, set_err;
      int per;
      per = 16 * (int'(div_n) + 1);
      line = !m_drive() && !nack;
      set_irq = 0; set_err = 0;
      if (!m_busy && m_full && tx_en) begin
        fq.delete();
        fq.push_back(1'b0);
        for (int i = 0; i < 8; i++) fq.push_back(m_data[i]);
        fq.push_back(^m_data);
        fq.push_back(1'b1);
        m_busy = 1; m_cnt = 0; m_full = 0;
      end else if (m_busy && tick_en) begin
        if (fq.size() == 1 && m_cnt == per / 2 - 1 && !line) set_err = 1;
        if (m_cnt == per - 1) begin
          m_cnt = 0;
          void'(fq.pop_front());
          if (fq.size() == 0) begin m_busy = 0; set_irq = 1; end
        end else m_cnt++;
      end
      if (set_irq) m_irq = 1; else if (irq_ack) m_irq = 0;
      if (set_err) m_err = 1; else if (err_clr) m_err = 0;
      if (wr_en) begin m_data = wr_data; m_full = 1; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        check(line_drive_low == m_drive(), "R1 R3 line drive", line_drive_low, m_drive());
        check(shift_empty == !m_busy, "R2 R5 shift_empty", shift_empty, !m_busy);
        check(buf_empty == !m_full, "R6 buf_empty", buf_empty, !m_full);
        check(irq == m_irq, "R7 irq", irq, m_irq);
        check(err_flag == m_err, "R8 err_flag", err_flag, m_err);
      end
    end
  end

  // count-source enable: constant or every other cycle
  initial begin
    forever begin
      @(negedge clk);
      tick_en = tick_alt ? ~tick_en : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy || (m_full && tx_en)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_err_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic wait_stop_bit();
    while (!(m_busy && fq.size() == 1)) @(negedge clk);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    check(buf_empty == 1 && shift_empty == 1 && irq == 0 && err_flag == 0 && line_drive_low == 0,
          "R9 reset state", {buf_empty, shift_empty, irq, err_flag, line_drive_low}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    check(buf_empty == 1 && shift_empty == 1 && line_drive_low == 0, "R9 after reset",
          {buf_empty, shift_empty, line_drive_low}, 3'b110);

    // R4: transmit disabled keeps the byte in the buffer
    write_byte(8'hA5);
    repeat (40) @(negedge clk);
    check(buf_empty == 0, "R4 held while disabled buf_empty", buf_empty, 0);
    check(shift_empty == 1, "R4 held while disabled shift_empty", shift_empty, 1);

    // R2: character length with div_n = 0 and constant ticks
    tx_en = 1'b1;
    while (shift_empty) @(negedge clk);
    len = 0;
    while (!shift_empty) begin len++; @(negedge clk); end
    check(len == 176, "R2 character length", len, 176);
    check(irq == 1, "R7 irq after stop bit", irq, 1);
    repeat (5) @(negedge clk);
    check(irq == 1, "R7 irq holds", irq, 1);
    pulse_ack();
    @(negedge clk);
    check(irq == 0, "R7 irq cleared", irq, 0);

    // R10: back-to-back characters
    write_byte(8'h3C);
    while (shift_empty) @(negedge clk);
    write_byte(8'hC3);
    check(buf_empty == 0, "R6 buffered during shift", buf_empty, 0);
    while (!shift_empty) @(negedge clk);
    len = 0;
    while (shift_empty) begin len++; @(negedge clk); end
    check(len == 1, "R10 gap between characters", len, 1);
    wait_idle();
    pulse_ack();

    // R4: dropping tx_en mid-character
    write_byte(8'h81);
    while (shift_empty) @(negedge clk);
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    write_byte(8'h7E);
    repeat (200) @(negedge clk);
    check(shift_empty == 1, "R4 character completed", shift_empty, 1);
    check(buf_empty == 0, "R4 next byte waits", buf_empty, 0);
    tx_en = 1'b1;
    wait_idle();
    pulse_ack();

    // R8: receiver pulls the wire low through the stop bit
    write_byte(8'h55);
    wait_stop_bit();
    nack = 1'b1;
    while (m_busy) @(negedge clk);
    nack = 1'b0;
    check(err_flag == 1, "R8 error signal seen", err_flag, 1);
    repeat (3) @(negedge clk);
    check(err_flag == 1, "R8 error flag holds", err_flag, 1);
    pulse_err_clr();
    @(negedge clk);
    check(err_flag == 0, "R8 error flag cleared", err_flag, 0);

    // R8: low only early in the stop bit is not sampled
    write_byte(8'h0F);
    wait_stop_bit();
    nack = 1'b1;
    repeat (3) @(negedge clk);
    nack = 1'b0;
    wait_idle();
    check(err_flag == 0, "R8 early low ignored", err_flag, 0);
    pulse_ack();

    // R2 R1: larger divisor with stalled ticks
    div_n = 4'd2;
    tick_alt = 1'b1;
    write_byte(8'h96);
    wait_idle();
    write_byte(8'h00);
    wait_idle();
    write_byte(8'hFF);
    wait_idle();
    check(irq == 1 && shift_empty == 1, "R2 slow characters done", {irq, shift_empty}, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule